// File: doc/BRIEF.md
# Processor Request to Internal Bus Translator

This block accepts one memory request at a time from a processor port and reissues it as a command on a shared internal bus. A read is turned into one of three read commands according to how many bytes it asks for, and any write becomes the single write command. The top bits of the address select the target: local memory, the register space, or one of two address translation units.

Reads to a translation unit are delayed transactions and may be answered with a retry. Each unit has its own backoff input. After a retry the block does not request the bus while the backoff of the unit that retried is high. When that backoff is low, the block requests the bus again and reissues the identical command, address and target. The processor side is told of malformed or unsupported requests through an error response, and those requests never reach the bus.

Top module: `req_xlate_top`

## Requirements
- R1: A read of 1, 2 or 4 bytes is issued with bus_cmd code 0 (plain read).
- R2: A read of 8 bytes is issued with code 1 (line read), and a read of 32 bytes with code 2 (multiple read).
- R3: A write of any valid size (1, 2, 4, 8 or 32 bytes) is issued with code 3 (write).
- R4: bus_tgt equals the two top address bits: 0 local memory, 1 register space, 2 translation unit A, 3 translation unit B. bus_addr carries the request address unchanged.
- R5: A request whose size is not 1, 2, 4, 8 or 32 gets resp_valid with resp_err=1 on the cycle after acceptance, and bus_req and bus_valid stay low.
- R6: A locked request to target 2 or 3 gets the same error response as R5 and is not forwarded. A locked request to target 0 or 1 is forwarded normally.
- R7: After a retry, while the backoff input of the retrying unit (backoff_a for target 2, backoff_b for target 3) is high, bus_req stays low. Once it drops, the request is reissued with the same command, address and target.
- R8: If the retrying unit's backoff is low when the retry arrives, bus_req rises on the next cycle, and the reissue follows one cycle after the grant. The other unit's backoff has no effect.
- R9: proc_ready is high only when idle. It goes low from the acceptance of a request until the cycle after resp_valid, so only one request is outstanding.
- R10: bus_req stays high until bus_gnt is seen. bus_valid is high for exactly one cycle, on the cycle after the grant. A completion gives resp_valid with resp_err=0 one cycle after bus_done.
- R11: After reset, proc_ready=1 and bus_req, bus_valid and resp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_lock | input | 1 | Locked (atomic) request |
| req_size | input | SIZE_W | Transfer size in bytes |
| req_addr | input | ADDR_W | Request address |
| proc_ready | output | 1 | Block idle, accepts a request |
| resp_valid | output | 1 | Response pulse to processor |
| resp_err | output | 1 | Response is an error |
| bus_req | output | 1 | Internal bus request |
| bus_gnt | input | 1 | Internal bus grant |
| bus_valid | output | 1 | Command issue pulse |
| bus_cmd | output | 2 | Command code |
| bus_addr | output | ADDR_W | Command address |
| bus_tgt | output | 2 | Decoded target |
| bus_done | input | 1 | Target completed the command |
| bus_retry | input | 1 | Target asked for a retry |
| backoff_a | input | 1 | Backoff from translation unit A |
| backoff_b | input | 1 | Backoff from translation unit B |

## Verification
A corrupted latched command or address shows up on bus_cmd or bus_addr at the first issue, or at the reissue after a retry. A state machine stuck in its hold state shows as a missing reissue, or as a reissue that comes later than two cycles after the backoff clears. A wrong error decision shows one cycle after acceptance, as a resp_valid where a bus request was due or as a bus request where an error response was due. A lost return to idle keeps proc_ready low past the cycle after the response.

// File: rtl/req_xlate_pkg.sv
package req_xlate_pkg;
  typedef enum logic [1:0] {
    CMD_RD      = 2'd0,
    CMD_RD_LINE = 2'd1,
    CMD_RD_MULT = 2'd2,
    CMD_WR      = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    TGT_LOCAL = 2'd0,
    TGT_REGS  = 2'd1,
    TGT_XU_A  = 2'd2,
    TGT_XU_B  = 2'd3
  } tgt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ISSUE,
    ST_WAIT,
    ST_HOLD,
    ST_RESP
  } xl_state_t;
endpackage

// File: rtl/xl_cmd_enc.sv
module xl_cmd_enc
  import req_xlate_pkg::*;
#(
  parameter int SIZE_W = 6
) (
  input  logic              is_write,
  input  logic [SIZE_W-1:0] nbytes,
  output bus_cmd_t          cmd,
  output logic              bad_size
);
  always_comb begin
    bad_size = 1'b0;
    cmd      = CMD_RD;
    if (nbytes == SIZE_W'(8))       cmd = CMD_RD_LINE;
    else if (nbytes == SIZE_W'(32)) cmd = CMD_RD_MULT;
    else if (nbytes == SIZE_W'(1) || nbytes == SIZE_W'(2) || nbytes == SIZE_W'(4))
      cmd = CMD_RD;
    else
      bad_size = 1'b1;
    if (is_write) cmd = CMD_WR;
  end
endmodule

// File: rtl/xl_tgt_dec.sv
module xl_tgt_dec
  import req_xlate_pkg::*;
(
  input  logic [1:0] top_bits,
  output tgt_t       tgt,
  output logic       is_xu
);
  always_comb begin
    tgt   = tgt_t'(top_bits);
    is_xu = (tgt == TGT_XU_A) || (tgt == TGT_XU_B);
  end
endmodule

// File: rtl/xl_ctrl.sv
module xl_ctrl
  import req_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      take,
  input  logic      reject,
  input  logic      gnt,
  input  logic      done,
  input  logic      retry,
  input  logic      bo_sel,
  output xl_state_t state
);
  xl_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (take) nxt = reject ? ST_RESP : ST_REQ;
      ST_REQ:   if (gnt) nxt = ST_ISSUE;
      ST_ISSUE: nxt = ST_WAIT;
      ST_WAIT:  if (done) nxt = ST_RESP;
                else if (retry) nxt = bo_sel ? ST_HOLD : ST_REQ;
      ST_HOLD:  if (!bo_sel) nxt = ST_REQ;
      ST_RESP:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/req_xlate_top.sv
module req_xlate_top
  import req_xlate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_lock,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              proc_ready,
  output logic              resp_valid,
  output logic              resp_err,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_tgt,
  input  logic              bus_done,
  input  logic              bus_retry,
  input  logic              backoff_a,
  input  logic              backoff_b
);
  localparam int TOP_LO = ADDR_W - 2;

  bus_cmd_t  enc_cmd;
  logic      enc_bad;
  tgt_t      dec_tgt;
  logic      dec_xu;
  xl_state_t st;
  logic      take, reject, bo_sel;
  bus_cmd_t  cmd_q;
  tgt_t      tgt_q;
  logic [ADDR_W-1:0] addr_q;
  logic      err_q;

  xl_cmd_enc #(.SIZE_W(SIZE_W)) u_enc (
    .is_write(req_write), .nbytes(req_size), .cmd(enc_cmd), .bad_size(enc_bad)
  );

  xl_tgt_dec u_dec (
    .top_bits(req_addr[ADDR_W-1:TOP_LO]), .tgt(dec_tgt), .is_xu(dec_xu)
  );

  assign take   = req_valid && (st == ST_IDLE);
  assign reject = enc_bad || (req_lock && dec_xu);
  assign bo_sel = (tgt_q == TGT_XU_A) ? backoff_a :
                  (tgt_q == TGT_XU_B) ? backoff_b : 1'b0;

  xl_ctrl u_ctrl (
    .clk(clk), .rst(rst), .take(take), .reject(reject), .gnt(bus_gnt),
    .done(bus_done), .retry(bus_retry), .bo_sel(bo_sel), .state(st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_RD;
      tgt_q  <= TGT_LOCAL;
      addr_q <= '0;
      err_q  <= 1'b0;
    end else if (take) begin
      cmd_q  <= enc_cmd;
      tgt_q  <= dec_tgt;
      addr_q <= req_addr;
      err_q  <= reject;
    end else if (st == ST_WAIT && bus_done) begin
      err_q  <= 1'b0;
    end
  end

  assign proc_ready = (st == ST_IDLE);
  assign bus_req    = (st == ST_REQ);
  assign bus_valid  = (st == ST_ISSUE);
  assign resp_valid = (st == ST_RESP);
  assign resp_err   = resp_valid && err_q;
  assign bus_cmd    = cmd_q;
  assign bus_addr   = addr_q;
  assign bus_tgt    = tgt_q;

  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_gnt |=> bus_req);

  // R9
  one_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(proc_ready && (bus_req || bus_valid)));

  // R7
  same_reissue_chk: assert property (@(posedge clk) disable iff (rst)
    !proc_ready && !$past(proc_ready) && !$past(rst) |->
      $stable(bus_cmd) && $stable(bus_addr) && $stable(bus_tgt));

  // R9
  back_idle_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> proc_ready);

  // R10
  pulse_issue_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> !bus_valid);
endmodule

// File: tb/tb_req_xlate_top.sv
module tb_req_xlate_top;
  localparam int ADDR_W = 16;
  localparam int SIZE_W = 6;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_lock = 0;
  logic [SIZE_W-1:0] req_size = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic proc_ready, resp_valid, resp_err, bus_req, bus_valid;
  logic bus_gnt = 0, bus_done = 0, bus_retry = 0, backoff_a = 0, backoff_b = 0;
  logic [1:0] bus_cmd, bus_tgt;
  logic [ADDR_W-1:0] bus_addr;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  req_xlate_top #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int sz, input bit wr, input bit lk, input logic [ADDR_W-1:0] ad,
                     input int nretry, input int hold, input bit other_bo);
    int tgt = int'(ad[ADDR_W-1 -: 2]);
    bit bad = !(sz == 1 || sz == 2 || sz == 4 || sz == 8 || sz == 32);
    bit err = bad || (lk && tgt >= 2);
    int ecmd = wr ? 3 : (sz == 8 ? 1 : (sz == 32 ? 2 : 0));
    int issues = 0, retries = 0, gap = -1, hcnt = 0, cyc = 0;
    bit pend = 0, got = 0;
    @(negedge clk);
    chk(proc_ready == 1, "R9 ready before", proc_ready, 1);
    req_valid = 1; req_write = wr; req_lock = lk; req_size = SIZE_W'(sz); req_addr = ad;
    @(negedge clk);
    req_valid = 0;
    if (other_bo) begin
      if (tgt == 2) backoff_b = 1; else backoff_a = 1;
    end
    while (!got && cyc < 60) begin
      bus_retry = 0; bus_done = 0;
      if (gap >= 0) gap++;
      if (hcnt > 0) begin
        chk(bus_req == 0, "R7 no request during backoff", bus_req, 0);
        hcnt--;
        if (hcnt == 0) begin
          if (tgt == 2) backoff_a = 0; else backoff_b = 0;
        end
      end
      if (resp_valid) begin
        chk(resp_err == err, "R5 R6 R10 response error flag", resp_err, err);
        chk(issues == (err ? 0 : 1 + nretry), "R5 R6 issue count", issues, err ? 0 : 1 + nretry);
        got = 1;
      end else begin
        chk(proc_ready == 0, "R9 ready low while busy", proc_ready, 0);
        if (err) chk(bus_req == 0 && bus_valid == 0, "R5 R6 nothing forwarded", bus_req, 0);
        if (bus_valid) begin
          chk(bus_cmd == ecmd, wr ? "R3 write command" : (sz == 8 || sz == 32 ? "R2 read command" : "R1 read command"), bus_cmd, ecmd);
          chk(bus_tgt == tgt && bus_addr == ad, "R4 target and address", bus_addr, ad);
          if (gap >= 0) begin
            chk(gap == 2 + hold, hold == 0 ? "R8 immediate reissue" : "R7 reissue after backoff", gap, 2 + hold);
            gap = -1;
          end
          issues++;
          pend = 1;
        end else if (pend) begin
          pend = 0;
          if (retries < nretry) begin
            retries++;
            bus_retry = 1;
            gap = 0;
            if (hold > 0) begin
              hcnt = hold;
              if (tgt == 2) backoff_a = 1; else backoff_b = 1;
            end
          end else bus_done = 1;
        end
      end
      bus_gnt = bus_req;
      @(negedge clk);
      cyc++;
    end
    bus_gnt = 0; bus_retry = 0; bus_done = 0; backoff_a = 0; backoff_b = 0;
    if (!got) chk(0, "R10 no response", 0, 1);
    chk(proc_ready == 1, "R9 ready after response", proc_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(proc_ready == 1 && bus_req == 0 && bus_valid == 0 && resp_valid == 0,
        "R11 reset state", {proc_ready, bus_req, bus_valid, resp_valid}, 8);
    rst = 0;
    for (int sz = 0; sz <= 40; sz++)
      for (int wr = 0; wr < 2; wr++)
        for (int lk = 0; lk < 2; lk++)
          for (int t = 0; t < 4; t++) begin
            logic [ADDR_W-1:0] ad = {t[1:0], 14'(sz * 97 + wr * 5 + lk * 3 + 1)};
            bit ok = (sz == 1 || sz == 2 || sz == 4 || sz == 8 || sz == 32) && !(lk && t >= 2);
            if (ok && t >= 2 && wr == 0)
              run(sz, 1'b0, lk[0], ad, 1 + (sz % 2), sz % 4, sz[0] ^ lk[0]);
            else
              run(sz, wr[0], lk[0], ad, 0, 0, 1'b0);
          end
    // R8 other unit's backoff held while retrying unit's backoff is low
    run(4, 0, 0, {2'd3, 14'h0aa}, 2, 0, 1'b1);
    run(32, 0, 0, {2'd2, 14'h155}, 1, 0, 1'b1);
    // R7 long backoff
    run(8, 0, 0, {2'd2, 14'h3c}, 1, 9, 1'b0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule